// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side slave of a small serial EEPROM. It oversamples the SCL and SDA lines with the system clock, finds START and STOP conditions, and shifts 8-bit words MSB first. It drives SDA only through an open-drain enable: a high `sda_oe_o` pulls the line low. It decodes the device address word against the chip-select pins and the density setting. It then runs byte writes, page writes, current-address reads, random reads and sequential reads.

Storage lives in a separate array controller. For each received data byte the engine issues a one-cycle write strobe with a word address. On the closing STOP it pulses a commit. The controller answers with a busy flag while its internal write runs. Read data comes back combinationally for the address on `rd_addr_o`. The parameter `ADDR_W` (7 to 11) selects the density. Word addresses of 8 bits or fewer use 8-byte pages, and wider ones use 16-byte pages.

The controller has ten states. ST_IDLE waits for START. ST_DEV receives the device word, ST_DEV_ACK acknowledges it, ST_WADDR receives the word address and ST_WADDR_ACK acknowledges it. ST_WDATA and ST_WDATA_ACK receive and acknowledge data bytes. ST_RDATA sends a byte, ST_RACK samples the master's acknowledge, and ST_WAIT_STOP stays silent until STOP or START.

The transitions are these. START takes any state to ST_DEV, and STOP takes any state to ST_IDLE. The others happen on a falling SCL:
- ST_DEV goes to ST_DEV_ACK on a match with no busy flag, and otherwise to ST_IDLE.
- ST_DEV_ACK goes to ST_RDATA for a read or to ST_WADDR for a write.
- ST_WADDR goes to ST_WADDR_ACK, and ST_WADDR_ACK goes to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate.
- ST_RDATA goes to ST_RACK.
- ST_RACK goes to ST_RDATA after a master ACK, or to ST_WAIT_STOP after a NACK.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts device-word decoding from any state, including partway through a byte.
- R2: A rising SDA while SCL is high (STOP) returns the engine to idle. After reset `sda_oe_o`, `wr_stb_o` and `commit_o` are all low.
- R3: The device word is bits [7:4] = 1010, then bits [3:1], then bit 0 = R/W (1 = read). For each of bits [3:1], device bit k+1 is compared with `chip_sel_i[k]` unless it is one of the page bits, which are the lowest `ADDR_W-8` of them. A mismatch gets no ACK, and the engine ignores all bytes until the next START.
- R4: After a matching device word, a write word address or a write data byte, `sda_oe_o` is high throughout the ninth SCL pulse.
- R5: `sda_oe_o` never changes while SCL is high. Read bits are sent MSB first.
- R6: A write takes one word-address byte and then data bytes. Each data byte gives one `wr_stb_o` pulse. A STOP gives `commit_o` only if at least one data byte was received.
- R7: While `busy_i` is high, a matching device word gets no ACK and the rest of that transfer is ignored. Once busy ends, the same word is ACKed.
- R8: In a page write, the address increments only within the page (8 bytes when `ADDR_W` ≤ 8, otherwise 16) and wraps to the page start.
- R9: A write header that carries only a word address, followed by a repeated START with R/W=1, reads from that address. A plain read continues from the last address plus one.
- R10: A sequential read increments across page boundaries and wraps from the top address to 0. After a master NACK the engine drives nothing until STOP or START.
- R11: The page bits of the device word form the word-address bits above bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| chip_sel_i | input | 3 | Hard-wired chip-select levels |
| busy_i | input | 1 | Array controller internal write in progress |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | ADDR_W | Word address for the strobed byte |
| wr_data_o | output | 8 | Data for the strobed byte |
| commit_o | output | 1 | One-cycle pulse starting the internal write |
| rd_addr_o | output | ADDR_W | Current word-address pointer |
| rd_data_i | input | 8 | Array data at `rd_addr_o` |

## Verification
A wrong state shows up at the ports within one byte time of the error. A missing ACK appears on the ninth SCL pulse, read data from the wrong address appears when the next byte is shifted out, and a stray strobe or commit appears on `wr_stb_o` or `commit_o`. A wrong bit count or pointer update stays hidden until a later read. For that reason, each write test is read back across the page boundary, the wrap points and the page-bit decode.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } slv_state_e;

    localparam int unsigned DEV_TAG = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_s, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_d <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_d <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_d <= sda_s;
        end
    end

    assign scl_lvl   = scl_s;
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edge while SCL held high on both samples
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/dev_word_match.sv
module dev_word_match #(
    parameter int ADDR_W = 9
) (
    input  logic [6:0]                  dev_hi,
    input  logic [2:0]                  chip_sel,
    output logic                        match,
    output logic [((ADDR_W > 8) ? ADDR_W - 8 : 1) - 1:0] page
);
    import eeprom_slave_pkg::*;

    localparam int PG_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
    localparam int PGW     = (PG_BITS > 0) ? PG_BITS : 1;

    logic [2:0] hit;

    // dev_hi[k] is device-word bit k+1; low PG_BITS of them are page bits
    for (genvar i = 0; i < 3; i++) begin : g_sel
        if (i < PG_BITS) begin : g_page
            assign hit[i] = 1'b1 | (dev_hi[i] ^ chip_sel[i]);
        end else begin : g_cmp
            assign hit[i] = (dev_hi[i] == chip_sel[i]);
        end
    end

    for (genvar j = 0; j < PGW; j++) begin : g_pg
        if (PG_BITS > 0) begin : g_on
            assign page[j] = dev_hi[j];
        end else begin : g_off
            assign page[j] = 1'b0;
        end
    end

    assign match = (dev_hi[6:3] == DEV_TAG[3:0]) && (&hit);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        chip_sel_i,
    input  logic              busy_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    localparam int PAGE_W  = (ADDR_W > 8) ? 4 : 3;
    localparam int PG_BITS = (ADDR_W > 8) ? ADDR_W - 8 : 0;
    localparam int PGW     = (PG_BITS > 0) ? PG_BITS : 1;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slv_state_e        st_q, st_d;
    logic [3:0]        cnt_q;
    logic [7:0]        sh_q;
    logic              rw_q;
    logic              m_ack_q;
    logic              have_data_q;
    logic [PGW-1:0]    page_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_pinc;
    logic [ADDR_W-1:0] addr_from_byte;
    logic              wr_stb_q, commit_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;
    logic              dev_match;
    logic [PGW-1:0]    dev_page;
    logic              byte_done;

    dev_word_match #(.ADDR_W(ADDR_W)) u_match (
        .dev_hi   (sh_q[7:1]),
        .chip_sel (chip_sel_i),
        .match    (dev_match),
        .page     (dev_page)
    );

    assign byte_done = (cnt_q == 4'd8);

    if (ADDR_W > 8) begin : g_paged
        assign addr_from_byte = {page_q, sh_q};
    end else begin : g_flat
        logic unused_hi;
        assign addr_from_byte = sh_q[ADDR_W-1:0];
        assign unused_hi      = ^{page_q, sh_q};
    end

    // increment confined to the current page
    always_comb begin
        ptr_pinc               = ptr_q;
        ptr_pinc[PAGE_W-1:0]   = ptr_q[PAGE_W-1:0] + 1'b1;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (start_det) begin
            st_d = ST_DEV;
        end else if (stop_det) begin
            st_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (st_q)
                ST_DEV:       if (byte_done) st_d = (dev_match && !busy_i) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   st_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) st_d = ST_WADDR_ACK;
                ST_WADDR_ACK: st_d = ST_WDATA;
                ST_WDATA:     if (byte_done) st_d = ST_WDATA_ACK;
                ST_WDATA_ACK: st_d = ST_WDATA;
                ST_RDATA:     if (byte_done) st_d = ST_RACK;
                ST_RACK:      st_d = m_ack_q ? ST_RDATA : ST_WAIT_STOP;
                default:      st_d = st_q;
            endcase
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            sh_q        <= '0;
            rw_q        <= 1'b0;
            m_ack_q     <= 1'b0;
            have_data_q <= 1'b0;
            page_q      <= '0;
            ptr_q       <= '0;
            wr_stb_q    <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
            commit_q    <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            commit_q <= 1'b0;
            if (start_det) begin
                cnt_q       <= '0;
                have_data_q <= 1'b0;
            end else if (stop_det) begin
                commit_q    <= (st_q == ST_WDATA) && have_data_q;
                have_data_q <= 1'b0;
            end else begin
                if (scl_rise) begin
                    unique case (st_q)
                        ST_DEV, ST_WADDR, ST_WDATA: begin
                            sh_q  <= {sh_q[6:0], sda_lvl};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        ST_RDATA: cnt_q   <= cnt_q + 4'd1;
                        ST_RACK:  m_ack_q <= ~sda_lvl;
                        default: ;
                    endcase
                end
                if (scl_fall) begin
                    unique case (st_q)
                        ST_DEV: if (byte_done) begin
                            rw_q   <= sh_q[0];
                            page_q <= dev_page;
                        end
                        ST_DEV_ACK: begin
                            cnt_q <= '0;
                            if (rw_q) sh_q <= rd_data_i;
                        end
                        ST_WADDR: if (byte_done) ptr_q <= addr_from_byte;
                        ST_WADDR_ACK, ST_WDATA_ACK: cnt_q <= '0;
                        ST_WDATA: if (byte_done) begin
                            wr_stb_q    <= 1'b1;
                            wr_addr_q   <= ptr_q;
                            wr_data_q   <= sh_q;
                            ptr_q       <= ptr_pinc;
                            have_data_q <= 1'b1;
                        end
                        ST_RDATA: begin
                            if (byte_done) ptr_q <= ptr_q + 1'b1;
                            else           sh_q  <= {sh_q[6:0], 1'b0};
                        end
                        ST_RACK: begin
                            cnt_q <= '0;
                            if (m_ack_q) sh_q <= rd_data_i;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (st_q)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = ~sh_q[7];
            default:                                sda_oe_o = 1'b0;
        endcase
    end

    assign wr_stb_o  = wr_stb_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;
    assign commit_o  = commit_q;
    assign rd_addr_o = ptr_q;

    // ---------------- assertions ----------------
    a_r1_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> st_q == ST_DEV);

    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> st_q == ST_IDLE);

    a_r5_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_det));

    a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_DEV_ACK) |-> !$past(busy_i));

    a_r8_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ptr_q[ADDR_W-1:PAGE_W] == wr_addr_o[ADDR_W-1:PAGE_W]);

endmodule

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;

    localparam int AW   = 9;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [2:0] chip_sel = 3'b101;
    logic busy;
    logic wr_stb, commit;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [7:0] mem [0:(1<<AW)-1];
    int busy_cnt, wr_cnt, commit_cnt, oe_bad;
    int checks = 0, fails = 0;
    logic scl_prev, oe_prev;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign busy     = (busy_cnt != 0);
    assign rd_data  = mem[rd_addr];

    serial_eeprom_slave #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .chip_sel_i(chip_sel), .busy_i(busy),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // array controller model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= init_val(i);
            busy_cnt <= 0; wr_cnt <= 0; commit_cnt <= 0;
        end else begin
            if (wr_stb) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (commit) begin
                commit_cnt <= commit_cnt + 1;
                busy_cnt   <= BUSY;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    // R5 monitor: output enable must hold while SCL is high
    always @(posedge clk) begin
        if (!rst_n) oe_bad <= 0;
        else if (scl_m && scl_prev && (sda_oe != oe_prev)) oe_bad <= oe_bad + 1;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (5) @(negedge clk);
    endtask

    task automatic clk_bit(input bit v, output bit s);
        sda_m = v; q();
        scl_m = 1'b1; q();
        s = sda_line; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(!ack, s);
    endtask

    task automatic wait_idle();
        while (busy_cnt != 0) @(negedge clk);
        q();
    endtask

    task automatic write_seq(input logic [7:0] dev, input logic [7:0] wa,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input int n, input string req);
        bit a;
        bus_start();
        send_byte(dev, a); chk(a, req, a, 1);
        send_byte(wa, a);  chk(a, "R4 word address ack", a, 1);
        send_byte(d0, a);  chk(a, "R4 data ack", a, 1);
        if (n > 1) begin send_byte(d1, a); chk(a, "R4 data ack", a, 1); end
        bus_stop();
    endtask

    task automatic dummy_then_read(input logic [7:0] dev, input logic [7:0] wa);
        bit a;
        bus_start();
        send_byte(dev, a);
        send_byte(wa, a);
        bus_start();
        send_byte(dev | 8'h01, a);
        chk(a, "R9 read header ack", a, 1);
    endtask

    // {device word, expected ack, expected read byte}
    localparam logic [16:0] VEC [8] = '{
        {8'hA8, 1'b1, 8'h00},
        {8'hAA, 1'b1, 8'h00},
        {8'hA9, 1'b1, 8'h5A},
        {8'hA0, 1'b0, 8'h00},
        {8'hAC, 1'b0, 8'h00},
        {8'hB8, 1'b0, 8'h00},
        {8'h28, 1'b0, 8'h00},
        {8'hAB, 1'b1, 8'h5B}
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit a, s;
        logic [7:0] d;
        int wc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        q();
        // R2 reset state
        chk(sda_oe == 1'b0, "R2 reset oe", sda_oe, 0);
        chk(wr_stb == 1'b0, "R2 reset strobe", wr_stb, 0);
        chk(commit == 1'b0, "R2 reset commit", commit, 0);

        // R3 address decode table (A2=1, A1=0, bit1 is a page bit)
        for (int k = 0; k < 8; k++) begin
            bus_start();
            send_byte(VEC[k][16:9], a);
            chk(a == VEC[k][8], "R3 device word ack", a, VEC[k][8]);
            if (a && VEC[k][9]) begin
                recv_byte(1'b0, d);
                chk(d == VEC[k][7:0], "R9 current read", d, VEC[k][7:0]);
            end
            bus_stop();
        end
        chk(wr_cnt == 0 && commit_cnt == 0, "R6 no write without data", wr_cnt + commit_cnt, 0);

        // R3 mismatch ignores following bytes
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h10, a); chk(!a, "R3 ignored byte", a, 0);
        send_byte(8'h33, a);
        bus_stop();
        chk(wr_cnt == 0, "R3 no strobe after mismatch", wr_cnt, 0);

        // R6 page write of three bytes
        bus_start();
        send_byte(8'hA8, a); send_byte(8'h10, a);
        send_byte(8'h11, a); send_byte(8'h22, a);
        send_byte(8'h33, a); chk(a, "R4 third data ack", a, 1);
        bus_stop();
        q();
        chk(wr_cnt == 3, "R6 strobes", wr_cnt, 3);
        chk(commit_cnt == 1, "R6 commit", commit_cnt, 1);

        // R7 busy: NACK and ignore
        wc = wr_cnt;
        bus_start();
        send_byte(8'hA8, a); chk(!a, "R7 nack while busy", a, 0);
        send_byte(8'h40, a); send_byte(8'h99, a);
        bus_stop();
        q();
        chk(wr_cnt == wc && commit_cnt == 1, "R7 busy ignored", wr_cnt, wc);
        wait_idle();
        bus_start();
        send_byte(8'hA8, a); chk(a, "R7 ack after busy", a, 1);
        bus_stop();
        q();
        chk(commit_cnt == 1, "R6 no commit header only", commit_cnt, 1);

        // R8 page wrap 0x1E..0x11
        bus_start();
        send_byte(8'hA8, a); send_byte(8'h1E, a);
        send_byte(8'hA1, a); send_byte(8'hA2, a);
        send_byte(8'hA3, a); send_byte(8'hA4, a);
        bus_stop();
        wait_idle();

        // R11 page bit write to 0x105
        write_seq(8'hAA, 8'h05, 8'h77, 8'h00, 1, "R11 paged header ack");
        wait_idle();

        // R9 R10 random then sequential read across page boundary
        dummy_then_read(8'hA8, 8'h0E);
        recv_byte(1'b1, d); chk(d == init_val(14), "R9 random read", d, init_val(14));
        recv_byte(1'b1, d); chk(d == init_val(15), "R10 seq read", d, init_val(15));
        recv_byte(1'b1, d); chk(d == 8'hA3, "R8 wrapped byte at 0x10", d, 8'hA3);
        recv_byte(1'b1, d); chk(d == 8'hA4, "R8 wrapped byte at 0x11", d, 8'hA4);
        recv_byte(1'b1, d); chk(d == 8'h33, "R6 untouched byte at 0x12", d, 8'h33);
        recv_byte(1'b0, d); chk(d == init_val(19), "R10 seq read", d, init_val(19));
        bus_stop();
        bus_start();
        send_byte(8'hA9, a);
        recv_byte(1'b0, d); chk(d == init_val(20), "R9 current read continues", d, init_val(20));
        bus_stop();

        dummy_then_read(8'hA8, 8'h1E);
        recv_byte(1'b1, d); chk(d == 8'hA1, "R8 byte at 0x1E", d, 8'hA1);
        recv_byte(1'b0, d); chk(d == 8'hA2, "R8 byte at 0x1F", d, 8'hA2);
        bus_stop();

        // R11 page bit selects upper half
        dummy_then_read(8'hAA, 8'h05);
        recv_byte(1'b0, d); chk(d == 8'h77, "R11 read 0x105", d, 8'h77);
        bus_stop();
        dummy_then_read(8'hA8, 8'h05);
        recv_byte(1'b0, d); chk(d == init_val(5), "R11 read 0x005", d, init_val(5));
        bus_stop();

        // R10 roll-over and silence after NACK
        dummy_then_read(8'hAA, 8'hFF);
        recv_byte(1'b1, d); chk(d == init_val(511), "R10 top address", d, init_val(511));
        recv_byte(1'b0, d); chk(d == init_val(0), "R10 roll to zero", d, init_val(0));
        recv_byte(1'b0, d); chk(d == 8'hFF, "R10 silent after nack", d, 8'hFF);
        bus_stop();

        // R1 restart in mid-byte
        bus_start();
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
        bus_start();
        send_byte(8'hA9, a); chk(a, "R1 restart ack", a, 1);
        recv_byte(1'b0, d); chk(d == init_val(1), "R1 read after restart", d, init_val(1));
        bus_stop();

        q();
        chk(oe_bad == 0, "R5 oe stable while SCL high", oe_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule